// File: doc/BRIEF.md
# Smart Sharpness Fader with Noise-Aware Coring

This block produces the final sharpened luminance sample of a video sharpness path. It builds a peaked sample by adding a contour correction to the delayed original luminance, and it blends that peaked sample toward a step-improved sample. The contour correction passes through a coring stage and a gain stage before it is added. The blend weight comes from the magnitude of a band-pass step-detector signal, scaled by a steepness setting. Because a band-pass detector grows with both the height and the slope of an edge, large steep transients take the step-improved path. Small detail keeps the peaked path.

Each user control is a 6-bit setting: peaking gain, steepness and coring level. A one-bit select picks the narrow or the wide contour input. An envelope input lowers the peaking gain as the local excursion grows. A noise level input lowers the effective steepness and raises the effective coring, and both reach their extreme at full scale. The result is clipped to the unsigned sample range and registered.

Top module: `sharp_fade_top`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `luma_out` is 0 whatever the inputs are.
- R2: `luma_out` is registered. It shows the result of the inputs sampled at the previous rising clock edge, one cycle of latency.
- R3: `wide_sel` = 0 uses `cont_narrow` as the contour and `wide_sel` = 1 uses `cont_wide`. The contour that is not selected has no effect.
- R4: Coring threshold thr = (core_eff * 56) >> 6, which is about 22% of the 256 contour full scale. A contour whose magnitude is no larger than thr contributes 0. A larger contour contributes its magnitude minus thr, with its own sign.
- R5: Peaking gain pk = (peak_set * (256 - envelope)) >> 8. The correction is (cored * pk) >>> 6, rounded toward minus infinity. The peaked sample is luma_dly + correction. At envelope 255 the peaking gain is 0.
- R6: Weight w = min(64, (|step_det| * steep_eff) >> 5). Only the magnitude of the detector counts, so its sign does not matter.
- R7: Before clipping, the output is peaked + (((luma_step - peaked) * w) >>> 6). At w = 0 this gives the peaked sample and at w = 64 it gives luma_step.
- R8: The output saturates to 0 below zero and to 255 above 255.
- R9: Noise weight nw = 64 when noise_lvl = 63, and nw = noise_lvl otherwise. steep_eff = (steep_set * (64 - nw)) >> 6 and core_eff = core_set + (((63 - core_set) * nw) >> 6). At noise 0 the settings pass unchanged. At noise 63 steepness is 0 and coring is at its maximum.
- R10: With peak_set = 0 and steep_set = 0, the output equals luma_dly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| peak_set | input | 6 | Peaking gain setting |
| steep_set | input | 6 | Steepness setting |
| core_set | input | 6 | Coring level setting |
| wide_sel | input | 1 | Contour select: 0 narrow, 1 wide |
| noise_lvl | input | 6 | Noise level that reduces the features |
| cont_narrow | input | 9 | Signed narrow-band contour |
| cont_wide | input | 9 | Signed wide-band contour |
| step_det | input | 9 | Signed band-pass step detector value |
| envelope | input | 8 | Local excursion envelope |
| luma_dly | input | 8 | Delayed original luminance |
| luma_step | input | 8 | Step-improved luminance |
| luma_out | output | 8 | Final luminance, registered |

## Verification
The bench builds the block with its default parameters: 8-bit samples, 9-bit signed contour and detector, 6-bit settings, detector shift 5 and the noise stage enabled. With these widths every extreme can be driven directly. Coring reaches its 55-code threshold cap, contour and detector inputs reach their -256 corner, the weight saturates at 64, and the peaked sum goes past both clip rails. These targeted cases are followed by a stretch of pseudo-random vectors against an independent arithmetic model, which also brings the noise level to 63.

// File: rtl/sharp_pkg.sv
package sharp_pkg;
   // contour selection code carried on wide_sel
   typedef enum logic {
      CONT_NARROW = 1'b0,
      CONT_WIDE   = 1'b1
   } cont_sel_e;

   // largest coring threshold, percent of contour full scale
   localparam int CORE_MAX_PCT = 22;
endpackage

// File: rtl/sharp_noise_ctl.sv
module sharp_noise_ctl #(
   parameter int SW       = 6,
   parameter bit NOISE_EN = 1'b1
) (
   input  logic [SW-1:0] steep_set,
   input  logic [SW-1:0] core_set,
   input  logic [SW-1:0] noise_lvl,
   output logic [SW-1:0] steep_eff,
   output logic [SW-1:0] core_eff
);
   localparam int FULL = 1 << SW;
   localparam int MAXS = FULL - 1;
   localparam int PWD  = 2 * SW + 2;

   generate
      if (NOISE_EN) begin : g_noise
         logic [SW:0] nw;
         // top code maps to full scale so that full reduction is exact
         assign nw = (noise_lvl == SW'(MAXS)) ? (SW+1)'(FULL) : {1'b0, noise_lvl};
         assign steep_eff = SW'((PWD'(steep_set) * PWD'((SW+1)'(FULL) - nw)) >> SW);
         assign core_eff  = core_set +
                            SW'((PWD'(SW'(MAXS) - core_set) * PWD'(nw)) >> SW);
      end else begin : g_plain
         logic unused_noise;
         assign unused_noise = ^noise_lvl;
         assign steep_eff = steep_set;
         assign core_eff  = core_set;
      end
   endgenerate
endmodule

// File: rtl/sharp_corer.sv
module sharp_corer #(
   parameter int CW = 9,
   parameter int SW = 6
) (
   input  logic signed [CW-1:0] cont_narrow,
   input  logic signed [CW-1:0] cont_wide,
   input  logic                 wide_sel,
   input  logic [SW-1:0]        core_eff,
   output logic [CW-1:0]        thr,
   output logic signed [CW:0]   cored
);
   import sharp_pkg::*;

   localparam int THR_MAX = ((1 << (CW - 1)) * CORE_MAX_PCT) / 100;
   localparam int TW      = CW + SW + 2;

   logic [CW-1:0] c_u;
   logic          neg;
   logic [CW-1:0] mag;
   logic [CW-1:0] cm;

   assign c_u = (cont_sel_e'(wide_sel) == CONT_WIDE) ? cont_wide : cont_narrow;
   assign neg = c_u[CW-1];
   assign mag = neg ? (~c_u + CW'(1)) : c_u;

   assign thr = CW'((TW'(core_eff) * TW'(THR_MAX)) >> SW);
   assign cm  = (mag > thr) ? (mag - thr) : '0;

   assign cored = neg ? -$signed({1'b0, cm}) : $signed({1'b0, cm});
endmodule

// File: rtl/sharp_peak.sv
module sharp_peak #(
   parameter int DW = 8,
   parameter int CW = 9,
   parameter int SW = 6,
   parameter int EW = 8,
   parameter int IW = 35
) (
   input  logic signed [CW:0]   cored,
   input  logic [SW-1:0]        peak_set,
   input  logic [EW-1:0]        envelope,
   input  logic [DW-1:0]        luma_dly,
   output logic signed [IW-1:0] peaked
);
   logic [SW-1:0]        pk_eff;
   logic signed [IW-1:0] corr;

   // gain falls linearly with the envelope
   assign pk_eff = SW'((IW'(peak_set) *
                        IW'((EW+1)'(1 << EW) - {1'b0, envelope})) >> EW);

   assign corr   = (IW'(cored) * $signed(IW'({1'b0, pk_eff}))) >>> SW;
   assign peaked = corr + $signed(IW'({1'b0, luma_dly}));
endmodule

// File: rtl/sharp_fader.sv
module sharp_fader #(
   parameter int DW     = 8,
   parameter int CW     = 9,
   parameter int SW     = 6,
   parameter int IW     = 35,
   parameter int DET_SH = 5
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic signed [CW-1:0] step_det,
   input  logic [SW-1:0]        steep_eff,
   input  logic signed [IW-1:0] peaked,
   input  logic [DW-1:0]        luma_step,
   output logic [SW:0]          weight,
   output logic [DW-1:0]        luma_out
);
   localparam int FULL = 1 << SW;
   localparam int MAXV = (1 << DW) - 1;

   logic [CW-1:0]        d_u;
   logic [CW-1:0]        dmag;
   logic [IW-1:0]        prod;
   logic signed [IW-1:0] diff;
   logic signed [IW-1:0] blend;
   logic [DW-1:0]        luma_d;

   assign d_u  = step_det;
   assign dmag = d_u[CW-1] ? (~d_u + CW'(1)) : d_u;
   assign prod = (IW'(dmag) * IW'(steep_eff)) >> DET_SH;
   assign weight = (prod > IW'(FULL)) ? (SW+1)'(FULL) : (SW+1)'(prod);

   assign diff  = $signed(IW'({1'b0, luma_step})) - peaked;
   assign blend = peaked + ((diff * $signed(IW'({1'b0, weight}))) >>> SW);

   assign luma_d = (blend < 0) ? '0 :
                   (blend > $signed(IW'(MAXV))) ? DW'(MAXV) : DW'(blend);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) luma_out <= '0;
      else        luma_out <= luma_d;
   end

   // R6: blend weight never exceeds unity
   a_r6_weight_cap: assert property (@(posedge clk) disable iff (!rst_n)
      weight <= (SW+1)'(FULL));

   // R7: zero weight passes an in-range peaked sample one cycle later
   a_r7_zero_weight: assert property (@(posedge clk) disable iff (!rst_n)
      (weight == '0 && peaked >= 0 && peaked <= $signed(IW'(MAXV)))
      |=> luma_out == $past(peaked[DW-1:0]));

   // R7: unity weight passes the step-improved sample
   a_r7_full_weight: assert property (@(posedge clk) disable iff (!rst_n)
      (weight == (SW+1)'(FULL)) |=> luma_out == $past(luma_step));

   // R8: a negative peaked sample with no fade clips to zero
   a_r8_clip_low: assert property (@(posedge clk) disable iff (!rst_n)
      (weight == '0 && peaked < 0) |=> luma_out == '0);
endmodule

// File: rtl/sharp_fade_top.sv
module sharp_fade_top #(
   parameter int DW       = 8,
   parameter int CW       = 9,
   parameter int SW       = 6,
   parameter int EW       = 8,
   parameter int DET_SH   = 5,
   parameter bit NOISE_EN = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [SW-1:0]        peak_set,
   input  logic [SW-1:0]        steep_set,
   input  logic [SW-1:0]        core_set,
   input  logic                 wide_sel,
   input  logic [SW-1:0]        noise_lvl,
   input  logic signed [CW-1:0] cont_narrow,
   input  logic signed [CW-1:0] cont_wide,
   input  logic signed [CW-1:0] step_det,
   input  logic [EW-1:0]        envelope,
   input  logic [DW-1:0]        luma_dly,
   input  logic [DW-1:0]        luma_step,
   output logic [DW-1:0]        luma_out
);
   import sharp_pkg::*;

   localparam int IW      = DW + CW + SW + EW + 4;
   localparam int THR_MAX = ((1 << (CW - 1)) * CORE_MAX_PCT) / 100;

   generate
      if (CW > DW + 1) begin : g_bad_cw
         $error("contour width must not exceed sample width plus one");
      end
      if (SW < 2) begin : g_bad_sw
         $error("setting width must be at least 2");
      end
      if (DET_SH >= IW) begin : g_bad_sh
         $error("detector shift too large");
      end
   endgenerate

   logic [SW-1:0]        steep_eff;
   logic [SW-1:0]        core_eff;
   logic [CW-1:0]        thr;
   logic signed [CW:0]   cored;
   logic signed [IW-1:0] peaked;
   logic [SW:0]          weight;

   sharp_noise_ctl #(.SW(SW), .NOISE_EN(NOISE_EN)) u_noise (
      .steep_set (steep_set),
      .core_set  (core_set),
      .noise_lvl (noise_lvl),
      .steep_eff (steep_eff),
      .core_eff  (core_eff)
   );

   sharp_corer #(.CW(CW), .SW(SW)) u_core (
      .cont_narrow (cont_narrow),
      .cont_wide   (cont_wide),
      .wide_sel    (wide_sel),
      .core_eff    (core_eff),
      .thr         (thr),
      .cored       (cored)
   );

   sharp_peak #(.DW(DW), .CW(CW), .SW(SW), .EW(EW), .IW(IW)) u_peak (
      .cored    (cored),
      .peak_set (peak_set),
      .envelope (envelope),
      .luma_dly (luma_dly),
      .peaked   (peaked)
   );

   sharp_fader #(.DW(DW), .CW(CW), .SW(SW), .IW(IW), .DET_SH(DET_SH)) u_fade (
      .clk       (clk),
      .rst_n     (rst_n),
      .step_det  (step_det),
      .steep_eff (steep_eff),
      .peaked    (peaked),
      .luma_step (luma_step),
      .weight    (weight),
      .luma_out  (luma_out)
   );

   // R4: coring threshold stays within its 22 percent cap
   a_r4_thr_cap: assert property (@(posedge clk) disable iff (!rst_n)
      thr <= CW'(THR_MAX));

   // R5: full envelope removes all peaking
   a_r5_env_full: assert property (@(posedge clk) disable iff (!rst_n)
      (envelope == '1) |-> peaked == $signed(IW'({1'b0, luma_dly})));

   generate
      if (NOISE_EN) begin : g_noise_chk
         // R9: full noise level removes steepness and maximises coring
         a_r9_noise_full: assert property (@(posedge clk) disable iff (!rst_n)
            (noise_lvl == '1) |-> (steep_eff == '0 && core_eff == '1));
         // R9: zero noise leaves the settings untouched
         a_r9_noise_zero: assert property (@(posedge clk) disable iff (!rst_n)
            (noise_lvl == '0) |-> (steep_eff == steep_set && core_eff == core_set));
      end
   endgenerate
endmodule

// File: tb/sharp_fade_top_tb.sv
module sharp_fade_top_tb;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [5:0]  peak_set = '0, steep_set = '0, core_set = '0, noise_lvl = '0;
   logic        wide_sel = 1'b0;
   logic signed [8:0] cont_narrow = '0, cont_wide = '0, step_det = '0;
   logic [7:0]  envelope = '0, luma_dly = '0, luma_step = '0;
   logic [7:0]  luma_out;

   int total = 0;
   int bad = 0;
   int exp_q[$];
   string tag_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   sharp_fade_top u_dut (
      .clk(clk), .rst_n(rst_n),
      .peak_set(peak_set), .steep_set(steep_set), .core_set(core_set),
      .wide_sel(wide_sel), .noise_lvl(noise_lvl),
      .cont_narrow(cont_narrow), .cont_wide(cont_wide), .step_det(step_det),
      .envelope(envelope), .luma_dly(luma_dly), .luma_step(luma_step),
      .luma_out(luma_out)
   );

   // independent arithmetic model of the requirements
   function automatic int model(int pk, int st, int co, int ws, int nz,
                                int cn, int cwv, int det, int env, int ld, int ls);
      int nw, se, ce, c, m, thr, cm, cd, pg, corr, pd, dm, w, b;
      nw = (nz == 63) ? 64 : nz;                       // R9
      se = (st * (64 - nw)) >> 6;
      ce = co + (((63 - co) * nw) >> 6);
      c  = ws ? cwv : cn;                              // R3
      m  = (c < 0) ? -c : c;
      thr = (ce * 56) >> 6;                            // R4
      cm = (m > thr) ? m - thr : 0;
      cd = (c < 0) ? -cm : cm;
      pg = (pk * (256 - env)) >> 8;                    // R5
      corr = (cd * pg) >>> 6;
      pd = ld + corr;
      dm = (det < 0) ? -det : det;                     // R6
      w  = (dm * se) >> 5;
      if (w > 64) w = 64;
      b  = pd + (((ls - pd) * w) >>> 6);               // R7
      if (b < 0) b = 0;                                // R8
      if (b > 255) b = 255;
      return b;
   endfunction

   task automatic drive(int pk, int st, int co, int ws, int nz, int cn, int cwv,
                        int det, int env, int ld, int ls, string tag);
      @(negedge clk);
      peak_set = 6'(pk); steep_set = 6'(st); core_set = 6'(co);
      wide_sel = ws[0]; noise_lvl = 6'(nz);
      cont_narrow = 9'(cn); cont_wide = 9'(cwv); step_det = 9'(det);
      envelope = 8'(env); luma_dly = 8'(ld); luma_step = 8'(ls);
      exp_q.push_back(model(pk, st, co, ws, nz, cn, cwv, det, env, ld, ls));
      tag_q.push_back(tag);
   endtask

   // monitor: each result appears one edge after its inputs (R2)
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (exp_q.size() > 0) begin
            int e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            total++;
            if (int'(luma_out) != e) begin
               bad++;
               $display("FAIL %s (R2 latency): got %0d expected %0d", t, luma_out, e);
            end
         end
      end
   end

   initial begin
      #(CLK_PERIOD * 200000);
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      // R1: output held at zero in reset with busy inputs
      peak_set = 6'd63; luma_dly = 8'd200; luma_step = 8'd90; cont_narrow = 9'sd100;
      repeat (3) @(negedge clk);
      total++;
      if (luma_out != 8'd0) begin
         bad++;
         $display("FAIL R1 reset: got %0d expected 0", luma_out);
      end
      rst_n = 1'b1;
      #1;
      total++;
      if (luma_out != 8'd0) begin
         bad++;
         $display("FAIL R1 after release: got %0d expected 0", luma_out);
      end

      // R10: zero gains pass the delayed luminance
      drive(0, 0, 0, 0, 0, 120, -90, 200, 0, 77, 200, "R10 zero gains");
      // R3: narrow then wide contour, opposite signs
      drive(63, 0, 0, 0, 0, 40, -40, 0, 0, 100, 0, "R3 narrow");
      drive(63, 0, 0, 1, 0, 40, -40, 0, 0, 100, 0, "R3 wide");
      drive(63, 0, 0, 1, 0, 90, -40, 0, 0, 100, 0, "R3 narrow ignored");
      // R4: below and above the maximum threshold of 55
      drive(63, 0, 63, 0, 0, 55, 0, 0, 0, 100, 0, "R4 at threshold");
      drive(63, 0, 63, 0, 0, 100, 0, 0, 0, 100, 0, "R4 above threshold");
      drive(63, 0, 63, 0, 0, -100, 0, 0, 0, 100, 0, "R4 negative cored");
      // R5: envelope reduces peaking, full envelope removes it
      drive(63, 0, 0, 0, 0, 100, 0, 0, 128, 100, 0, "R5 half envelope");
      drive(63, 0, 0, 0, 0, 100, 0, 0, 255, 100, 0, "R5 full envelope");
      drive(63, 0, 0, 0, 0, -7, 0, 0, 0, 100, 0, "R5 floor rounding");
      // R6 / R7: weight saturation and sign of detector
      drive(0, 63, 0, 0, 0, 0, 0, 64, 0, 30, 220, "R7 full weight");
      drive(0, 63, 0, 0, 0, 0, 0, -64, 0, 30, 220, "R6 negative detector");
      drive(0, 63, 0, 0, 0, 0, 0, -256, 0, 30, 220, "R6 detector corner");
      drive(0, 32, 0, 0, 0, 0, 0, 8, 0, 30, 220, "R6 partial weight");
      drive(0, 32, 0, 0, 0, 0, 0, 8, 0, 220, 30, "R7 falling blend");
      // R8: clip rails
      drive(63, 0, 0, 0, 0, 200, 0, 0, 0, 250, 0, "R8 clip high");
      drive(63, 0, 0, 0, 0, -256, 0, 0, 0, 5, 0, "R8 clip low");
      // R9: noise reduces steepness and raises coring
      drive(63, 63, 0, 0, 63, 50, 0, 100, 0, 100, 250, "R9 full noise");
      drive(63, 63, 10, 0, 32, 60, 0, 20, 0, 100, 250, "R9 half noise");
      drive(63, 63, 10, 0, 0, 60, 0, 20, 0, 100, 250, "R9 zero noise");

      // mixed pseudo-random patterns, R2 through R9
      for (int i = 0; i < 80; i++) begin
         drive($urandom_range(63), $urandom_range(63), $urandom_range(63),
               $urandom_range(1), (i % 5 == 0) ? 63 : $urandom_range(63),
               int'($urandom_range(511)) - 256, int'($urandom_range(511)) - 256,
               int'($urandom_range(511)) - 256, $urandom_range(255),
               $urandom_range(255), $urandom_range(255), "R7 random mix");
      end

      @(negedge clk);
      repeat (3) @(negedge clk);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule